// File: doc/BRIEF.md
# Radio Power-State Controller

This block sits on the radio side of a link-layer/radio split and tracks the operating state of the radio. It takes a reset request from the link controller, the transmit and receive enables, a power-mode code written into a register, and the enable bit for channel-busy (CCA) reporting. From these it decides whether the radio is resetting, asleep, on standby, ready, transmitting or receiving. It drives the busy/acknowledge line back to the link controller, a ready status bit, a sleep flag that stands for stopping the clock, and a gate that says when CCA results may be reported.

The acknowledge line carries two handshakes. During a reset it stays high until the internal reset work is done. When the radio is woken from sleep it goes high once standby is reached, and it drops after the link controller releases both enables. The same two enables also start and end transmit and receive when the radio is ready. Power-mode writes that arrive while a frame is in progress are held until the radio is back in the ready state.

Top module: `radio_pwr_fsm`

## Requirements
- R1: While `phy_rst` is sampled high, and during the reset sequence that follows it or `rst_n`, `pwr_state` reads 0 (RESET), `phy_active` is 1 and `rdy` is 0. A reset request overrides every state.
- R2: The state changes to 2 (STANDBY) on the RST_CYCLES-th clock edge that samples `phy_rst` low inside RESET. At that edge `phy_active` falls and `rdy` becomes 1.
- R3: In SLEEP (code 1), `tx_en` and `rx_en` sampled high together move the state to STANDBY with `phy_active` high. `phy_active` stays high until an edge samples both enables low.
- R4: A `pm_wr` pulse with `pm_code` 0x00 requests READY (code 3), MODE_STBY (default 0x01) requests STANDBY and MODE_SLEEP (default 0x02) requests SLEEP. The state changes on the edge after the one that samples the write. Other codes, and writes sampled during RESET, have no effect.
- R5: In READY, `tx_en` alone enters 4 (TRANSMIT) and `rx_en` alone enters 5 (RECEIVE), one edge later. Both enables together leave the state at READY. Releasing the enable in use returns to READY.
- R6: A mode write sampled in TRANSMIT or RECEIVE does not change the state. It is applied on the edge after the state returns to READY.
- R7: `cca_ok` is 0 in RESET, SLEEP, STANDBY and TRANSMIT.
- R8: `cca_ok` goes to 1 (in READY or RECEIVE) only after CCA_CYCLES edges have sampled `cca_en` high. It is 0 whenever `cca_en` is 0.
- R9: `clk_stop` is 1 exactly when the state is SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a reset sequence |
| phy_rst | input | 1 | Reset request from the link controller |
| tx_en | input | 1 | Transmit enable / wake handshake |
| rx_en | input | 1 | Receive enable / wake handshake |
| pm_wr | input | 1 | One-cycle strobe for a power-mode register write |
| pm_code | input | 8 | Power-mode code being written |
| cca_en | input | 1 | CCA reporting enable bit |
| phy_active | output | 1 | Reset-in-progress / wake acknowledge |
| pwr_state | output | 3 | Current state: 0 RESET, 1 SLEEP, 2 STANDBY, 3 READY, 4 TRANSMIT, 5 RECEIVE |
| rdy | output | 1 | Reset completed |
| cca_ok | output | 1 | CCA reporting allowed |
| clk_stop | output | 1 | Clock would be stopped (SLEEP) |

## Verification
The properties assume that the link controller follows the handshake. The enables are never both high during a frame. A wake starts only in SLEEP and ends with both enables released before any further mode write. The stimulus keeps to these rules by driving every input once per cycle, well away from the active edge. It releases the wake enables together, and it raises a single enable only from READY. The one exception is the deliberate case of both enables raised in READY, which checks that the state does not change.

// File: rtl/radio_pwr_pkg.sv
// Package: shared state and mode-target types for the radio power controller.
// Assumes: the state encoding is visible at the block's ports and must stay fixed.
package radio_pwr_pkg;

    typedef enum logic [2:0] {
        PS_RESET   = 3'd0,
        PS_SLEEP   = 3'd1,
        PS_STANDBY = 3'd2,
        PS_READY   = 3'd3,
        PS_TX      = 3'd4,
        PS_RX      = 3'd5
    } pwr_state_t;

    typedef enum logic [1:0] {
        TGT_READY   = 2'd0,
        TGT_STANDBY = 2'd1,
        TGT_SLEEP   = 2'd2
    } pm_target_t;

endpackage

// File: rtl/rp_reset_timer.sv
// Module: counts the internal reset work after the reset request is released.
// Assumes: 'active' is high while the controller sits in RESET; 'hold' restarts the count.
module rp_reset_timer #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Finish when the last cycle of reset work is reached with the request released.
    assign done = active && !hold && (cnt == LAST);

    // Count reset-work cycles; restart on request, on hard reset, or outside RESET.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || !active) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rp_mode_hold.sv
// Module: decodes power-mode writes and keeps the latest valid request until used.
// Assumes: 'take' is raised by the state machine only when it applies the request.
module rp_mode_hold
    import radio_pwr_pkg::*;
#(
    parameter logic [7:0] MODE_STBY  = 8'h01,
    parameter logic [7:0] MODE_SLEEP = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       wr,
    input  logic [7:0] code,
    input  logic       take,
    output logic       pend_vld,
    output pm_target_t pend_tgt
);
    localparam logic [7:0] MODE_RDY = 8'h00;

    logic       code_ok;
    pm_target_t code_tgt;

    // Map a written code onto a target state; unknown codes are not accepted.
    always_comb begin
        code_ok  = 1'b1;
        code_tgt = TGT_READY;
        if (code == MODE_RDY) begin
            code_tgt = TGT_READY;
        end else if (code == MODE_STBY) begin
            code_tgt = TGT_STANDBY;
        end else if (code == MODE_SLEEP) begin
            code_tgt = TGT_SLEEP;
        end else begin
            code_ok = 1'b0;
        end
    end

    // Hold the newest accepted request; a new write replaces an older one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pend_vld <= 1'b0;
            pend_tgt <= TGT_READY;
        end else if (wr && code_ok) begin
            pend_vld <= 1'b1;
            pend_tgt <= code_tgt;
        end else if (take) begin
            pend_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/rp_cca_window.sv
// Module: times the settling interval after CCA reporting is enabled and gates the report.
// Assumes: 'allow' reflects the states in which reporting is permitted.
module rp_cca_window #(
    parameter int CCA_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic allow,
    output logic report
);
    localparam int CW = $clog2(CCA_CYCLES + 1);
    localparam logic [CW-1:0] FULL = CW'(CCA_CYCLES);

    logic [CW-1:0] cnt;

    // Report only once the interval has elapsed and the state permits it.
    assign report = enable && allow && (cnt == FULL);

    // Count cycles with the enable set; saturate at the full interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt <= '0;
        end else if (cnt != FULL) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/radio_pwr_fsm.sv
// Module: radio power-state controller (top). Tracks RESET/SLEEP/STANDBY/READY/TX/RX,
// drives the reset and wake acknowledge, the ready bit, the sleep flag and the CCA gate.
// Assumes: all inputs are synchronous to clk; pm_wr is a one-cycle strobe.
module radio_pwr_fsm
    import radio_pwr_pkg::*;
#(
    parameter int         RST_CYCLES = 4,
    parameter int         CCA_CYCLES = 6,
    parameter logic [7:0] MODE_STBY  = 8'h01,
    parameter logic [7:0] MODE_SLEEP = 8'h02
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phy_rst,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       pm_wr,
    input  logic [7:0] pm_code,
    input  logic       cca_en,
    output logic       phy_active,
    output logic [2:0] pwr_state,
    output logic       rdy,
    output logic       cca_ok,
    output logic       clk_stop
);
    pwr_state_t st, nxt;
    logic       wake_ack, ack_nxt;
    logic       rst_done;
    logic       take;
    logic       pend_vld;
    pm_target_t pend_tgt;
    logic       cca_allow;

    // Translate a held mode request into its destination state.
    function automatic pwr_state_t tgt_state(input pm_target_t t);
        case (t)
            TGT_STANDBY: return PS_STANDBY;
            TGT_SLEEP:   return PS_SLEEP;
            default:     return PS_READY;
        endcase
    endfunction

    rp_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (phy_rst),
        .active (st == PS_RESET),
        .done   (rst_done)
    );

    rp_mode_hold #(.MODE_STBY(MODE_STBY), .MODE_SLEEP(MODE_SLEEP)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (phy_rst || (st == PS_RESET)),
        .wr       (pm_wr),
        .code     (pm_code),
        .take     (take),
        .pend_vld (pend_vld),
        .pend_tgt (pend_tgt)
    );

    assign cca_allow = (st == PS_READY) || (st == PS_RX);

    rp_cca_window #(.CCA_CYCLES(CCA_CYCLES)) u_cca (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cca_en),
        .allow  (cca_allow),
        .report (cca_ok)
    );

    // Next-state decision: reset request first, then wake, held mode, enables.
    always_comb begin
        nxt     = st;
        ack_nxt = wake_ack;
        take    = 1'b0;
        if (phy_rst) begin
            nxt     = PS_RESET;
            ack_nxt = 1'b0;
        end else begin
            case (st)
                PS_RESET: begin
                    if (rst_done) nxt = PS_STANDBY;
                end
                PS_SLEEP: begin
                    if (tx_en && rx_en) begin
                        nxt     = PS_STANDBY;
                        ack_nxt = 1'b1;
                    end else if (pend_vld) begin
                        take = 1'b1;
                        nxt  = tgt_state(pend_tgt);
                    end
                end
                PS_STANDBY: begin
                    if (wake_ack) begin
                        if (!tx_en && !rx_en) ack_nxt = 1'b0;
                    end else if (pend_vld) begin
                        take = 1'b1;
                        nxt  = tgt_state(pend_tgt);
                    end
                end
                PS_READY: begin
                    if (pend_vld) begin
                        take = 1'b1;
                        nxt  = tgt_state(pend_tgt);
                    end else if (tx_en && !rx_en) begin
                        nxt = PS_TX;
                    end else if (rx_en && !tx_en) begin
                        nxt = PS_RX;
                    end
                end
                PS_TX: begin
                    if (!tx_en) nxt = PS_READY;
                end
                PS_RX: begin
                    if (!rx_en) nxt = PS_READY;
                end
                default: nxt = PS_RESET;
            endcase
        end
    end

    // State and wake-acknowledge registers; hard reset starts a reset sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_RESET;
            wake_ack <= 1'b0;
        end else begin
            st       <= nxt;
            wake_ack <= ack_nxt;
        end
    end

    // Ready bit: cleared by any reset, set when the reset work completes.
    always_ff @(posedge clk) begin
        if (!rst_n || phy_rst) begin
            rdy <= 1'b0;
        end else if (rst_done) begin
            rdy <= 1'b1;
        end
    end

    assign phy_active = (st == PS_RESET) || wake_ack;
    assign pwr_state  = st;
    assign clk_stop   = (st == PS_SLEEP);
endmodule

// File: rtl/radio_pwr_fsm_chk.sv
// Module: property checker for radio_pwr_fsm, attached with bind below.
// Assumes: port-level view only; state codes as listed in the brief.
module radio_pwr_fsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phy_rst,
    input logic       tx_en,
    input logic       rx_en,
    input logic       phy_active,
    input logic [2:0] pwr_state,
    input logic       rdy,
    input logic       cca_ok
);
    a_r1_reset_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst |=> (pwr_state == 3'd0) && phy_active && !rdy);

    a_r2_exit_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd2 && $past(pwr_state) == 3'd0) |-> rdy && !phy_active);

    a_r3_wake_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd1 && tx_en && rx_en && !phy_rst) |=> (pwr_state == 3'd2) && phy_active);

    a_r5_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && !tx_en && !phy_rst) |=> pwr_state == 3'd3);

    a_r7_cca_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0 || pwr_state == 3'd1 || pwr_state == 3'd2 || pwr_state == 3'd4) |-> !cca_ok);
endmodule

bind radio_pwr_fsm radio_pwr_fsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phy_rst    (phy_rst),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .phy_active (phy_active),
    .pwr_state  (pwr_state),
    .rdy        (rdy),
    .cca_ok     (cca_ok)
);

// File: tb/radio_pwr_fsm_bench.sv
// Bench: scoreboard for radio_pwr_fsm. The driver pushes expected port values into a
// queue after each stimulus step; the monitor pops and compares them at the falling edge.
module radio_pwr_fsm_bench;
    localparam int RST_CYCLES = 4;
    localparam int CCA_CYCLES = 6;

    localparam logic [2:0] S_RST = 3'd0, S_SLP = 3'd1, S_STB = 3'd2,
                           S_RDY = 3'd3, S_TX = 3'd4, S_RX = 3'd5;

    typedef struct {
        string      tag;
        logic [2:0] st;
        bit         act;
        bit         rd;
        bit         cca;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phy_rst = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       pm_wr = 1'b0;
    logic [7:0] pm_code = 8'h00;
    logic       cca_en = 1'b0;
    logic       phy_active, rdy, cca_ok, clk_stop;
    logic [2:0] pwr_state;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    radio_pwr_fsm #(.RST_CYCLES(RST_CYCLES), .CCA_CYCLES(CCA_CYCLES)) u_radio_pwr_fsm (
        .clk(clk), .rst_n(rst_n), .phy_rst(phy_rst), .tx_en(tx_en), .rx_en(rx_en),
        .pm_wr(pm_wr), .pm_code(pm_code), .cca_en(cca_en),
        .phy_active(phy_active), .pwr_state(pwr_state), .rdy(rdy),
        .cca_ok(cca_ok), .clk_stop(clk_stop)
    );

    always #10 clk = ~clk;

    task automatic slot();
        @(negedge clk);
        #2;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [2:0] st, input bit act,
                              input bit rd, input bit cca);
        exp_t e;
        e.tag = tag; e.st = st; e.act = act; e.rd = rd; e.cca = cca;
        sb.push_back(e);
    endtask

    // Monitor: compare every queued expectation against the ports at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                logic [4:0] got, want;
                e = sb.pop_front();
                got  = {pwr_state, phy_active, rdy};
                want = {e.st, e.act, e.rd};
                n_chk++;
                if (got !== want || cca_ok !== e.cca || clk_stop !== (e.st == S_SLP)) begin
                    n_bad++;
                    $display("FAIL %s: state/act/rdy=%0d/%0b/%0b cca=%0b stop=%0b, expected %0d/%0b/%0b cca=%0b stop=%0b",
                             e.tag, pwr_state, phy_active, rdy, cca_ok, clk_stop,
                             e.st, e.act, e.rd, e.cca, (e.st == S_SLP));
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Driver: stimulus steps, each followed by the expected port values.
    initial begin
        step(3);
        expect_out("R1 hard reset holds RESET", S_RST, 1, 0, 0);
        slot(); rst_n = 1'b1;
        step(RST_CYCLES - 1);
        expect_out("R2 one edge before reset end", S_RST, 1, 0, 0);
        step(1);
        expect_out("R2 reset done to STANDBY", S_STB, 0, 1, 0);

        slot(); pm_wr = 1'b1; pm_code = 8'h00;
        step(1);
        expect_out("R4 write not yet applied", S_STB, 0, 1, 0);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R4 code 0x00 gives READY", S_RDY, 0, 1, 0);

        slot(); pm_wr = 1'b1; pm_code = 8'h07;
        step(1);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R4 unknown code ignored", S_RDY, 0, 1, 0);

        slot(); tx_en = 1'b1;
        step(1);
        expect_out("R5 tx_en enters TRANSMIT", S_TX, 0, 1, 0);
        slot(); pm_wr = 1'b1; pm_code = 8'h01;
        step(1);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R6 write held during TRANSMIT", S_TX, 0, 1, 0);
        slot(); tx_en = 1'b0;
        step(1);
        expect_out("R6 back to READY first", S_RDY, 0, 1, 0);
        step(1);
        expect_out("R6 held write applied", S_STB, 0, 1, 0);

        slot(); pm_wr = 1'b1; pm_code = 8'h00;
        step(1);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R4 STANDBY to READY", S_RDY, 0, 1, 0);
        slot(); rx_en = 1'b1;
        step(1);
        expect_out("R5 rx_en enters RECEIVE", S_RX, 0, 1, 0);
        slot(); rx_en = 1'b0;
        step(1);
        expect_out("R5 rx release to READY", S_RDY, 0, 1, 0);
        slot(); tx_en = 1'b1; rx_en = 1'b1;
        step(2);
        expect_out("R5 both enables stay READY", S_RDY, 0, 1, 0);
        slot(); tx_en = 1'b0; rx_en = 1'b0; cca_en = 1'b1;
        step(CCA_CYCLES - 1);
        expect_out("R8 cca not yet valid", S_RDY, 0, 1, 0);
        step(1);
        expect_out("R8 cca valid after interval", S_RDY, 0, 1, 1);
        slot(); rx_en = 1'b1;
        step(1);
        expect_out("R7 cca allowed in RECEIVE", S_RX, 0, 1, 1);
        slot(); rx_en = 1'b0;
        step(1);
        expect_out("R7 cca in READY", S_RDY, 0, 1, 1);
        slot(); tx_en = 1'b1;
        step(1);
        expect_out("R7 cca blocked in TRANSMIT", S_TX, 0, 1, 0);
        slot(); tx_en = 1'b0;
        step(1);
        expect_out("R7 cca back in READY", S_RDY, 0, 1, 1);
        slot(); cca_en = 1'b0;
        step(1);
        expect_out("R8 cca off with enable low", S_RDY, 0, 1, 0);

        slot(); cca_en = 1'b1; pm_wr = 1'b1; pm_code = 8'h02;
        step(1);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R9 SLEEP raises clk_stop", S_SLP, 0, 1, 0);
        step(CCA_CYCLES);
        expect_out("R7 cca blocked in SLEEP", S_SLP, 0, 1, 0);
        slot(); tx_en = 1'b1; rx_en = 1'b1;
        step(1);
        expect_out("R3 wake reaches STANDBY with ack", S_STB, 1, 1, 0);
        step(1);
        expect_out("R3 ack held while enables high", S_STB, 1, 1, 0);
        slot(); tx_en = 1'b0; rx_en = 1'b0;
        step(1);
        expect_out("R3 ack drops after release", S_STB, 0, 1, 0);
        slot(); pm_wr = 1'b1; pm_code = 8'h00;
        step(1);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R7 cca valid again in READY", S_RDY, 0, 1, 1);

        slot(); cca_en = 1'b0; phy_rst = 1'b1;
        step(1);
        expect_out("R1 reset request from READY", S_RST, 1, 0, 0);
        slot(); pm_wr = 1'b1; pm_code = 8'h02;
        step(1);
        slot(); pm_wr = 1'b0;
        step(1);
        expect_out("R1 stays RESET while requested", S_RST, 1, 0, 0);
        slot(); phy_rst = 1'b0;
        step(RST_CYCLES);
        expect_out("R2 reset request completes", S_STB, 0, 1, 0);
        step(2);
        expect_out("R4 write during reset discarded", S_STB, 0, 1, 0);

        slot();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule